// File: doc/BRIEF.md
# Update-only line coherence controller

This controller manages the coherence state of one line in a private cache. Besides the usual invalid, shared, exclusive and modified states it has an update-only state. In that state the cache may apply commutative updates (add, AND, OR, XOR) to its copy without read permission. The copy holds only a partial result, which starts from the operation's identity value. The partial goes back to the shared level when the line is evicted, invalidated or downgraded, and the shared level folds it in there.

The core issues read, write and commutative-update requests, one word at a time. The line holds eight 64-bit words. A request that the current permission covers completes locally in one cycle. A request it does not cover sends a permission request to the directory and sets the busy flag until a grant comes back. The directory sends grants, invalidations and downgrades. The controller answers with acknowledgements, full data, or partial updates on a single outgoing message channel.

Top module: `upd_line_ctrl`

## Requirements
- R1: After reset the tag is invalid (0000), `busy` is low, and no `core_done`, `req_valid` or `msg_valid` pulse is produced until a request arrives.
- R2: `line_tag` encodes the state and the update operation in four bits: 0000 invalid, 0100 shared, 1000 exclusive, 1001 modified, and 11oo update-only, where oo is the operation.
- R3: A read (core_kind 0) that hits in shared, exclusive or modified returns the addressed word on `core_rdata` with `core_done` one cycle later. A write (kind 1) that hits in exclusive or modified stores the word and leaves the line modified.
- R4: A commutative update (kind 2) hits in exclusive, in modified, or in update-only with the same operation. It combines the word in one step, with operation codes 0 add modulo 2^64, 1 AND, 2 OR and 3 XOR. It pulses `core_done` one cycle later with the new word on `core_rdata`. An exclusive line becomes modified.
- R5: A request that misses raises `req_valid` one cycle later. The request kind is 0 shared, 1 write or 2 update-only, with the operation on `req_op`. `busy` stays high until a grant, and core requests made while `busy` is high have no effect.
- R6: A grant (dir_kind 0) that completes a miss fills the line from `dir_line` and pulses `core_done`. A read gives exclusive if `dir_excl` is set, otherwise shared. A write gives modified. An update with `dir_excl` set gives modified with the operation applied to the filled word. An update without it gives update-only, with the addressed word equal to the operand.
- R7: Entering update-only sets every word not updated to the identity: all ones for AND, zero for add, OR and XOR.
- R8: An invalidation (dir_kind 1) sends a partial (msg_kind 2) with line and operation from update-only, full data (msg_kind 1) from modified, or an acknowledgement (msg_kind 0) otherwise. The line then becomes invalid.
- R9: A downgrade (dir_kind 2) sends the line from exclusive, modified or update-only: data from E/M, a partial from U. The line then becomes update-only with `dir_op`, and all words are reset to its identity. From shared or invalid it acknowledges and goes invalid.
- R10: An eviction sends a partial from update-only, data from modified, and nothing from shared or exclusive. The line then becomes invalid. An eviction while `busy` is high has no effect.
- R11: A read or write to an update-only line, or an update with a different operation, first sends the partial and invalidates the line, then issues its permission request in the same cycle.
- R12: A core request made in the same cycle as a directory message or an eviction is dropped: no `core_done` and no `req_valid` follow.
- R13: A grant that arrives while no request is pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request strobe |
| core_kind | input | 2 | 0 read, 1 write, 2 commutative update |
| core_op | input | 2 | Update operation: 0 add, 1 AND, 2 OR, 3 XOR |
| core_word | input | 3 | Word index within the line |
| core_wdata | input | 64 | Write data or update operand |
| evict | input | 1 | Replacement asks to drop the line |
| dir_valid | input | 1 | Directory message strobe |
| dir_kind | input | 2 | 0 grant, 1 invalidate, 2 downgrade, 3 none |
| dir_excl | input | 1 | Grant: no other cache holds a valid copy |
| dir_op | input | 2 | Downgrade: operation of the new update-only line |
| dir_line | input | 512 | Grant fill data, word i at bits 64i+63..64i |
| busy | output | 1 | Permission request outstanding |
| core_done | output | 1 | Core request completed |
| core_rdata | output | 64 | Read data or resulting word |
| req_valid | output | 1 | Permission request strobe |
| req_kind | output | 2 | 0 shared, 1 write, 2 update-only |
| req_op | output | 2 | Operation for an update-only request |
| msg_valid | output | 1 | Reply/writeback strobe |
| msg_kind | output | 2 | 0 acknowledge, 1 full data, 2 partial |
| msg_op | output | 2 | Operation of a partial |
| msg_line | output | 512 | Line contents sent with the message |
| line_tag | output | 4 | Coherence state and update operation |

## Verification
The hardest situation to reach is a line in update-only state with one operation that then meets an update of another operation, or a downgrade that names another operation. Either way the partial must leave with the old operation while the words restart from the new identity. The bench gets there through a sequence of its own: it first acquires update-only with add through a non-exclusive grant, then issues a different operation or downgrade. It also drives core requests together with directory messages, and grants with nothing pending, because the directory would never produce those pairings on its own. A behavioural model follows every cycle, so each partial's contents are compared word by word.

// File: rtl/upd_line_ctrl.sv
module upd_line_ctrl #(
  parameter int WORDS = 8,
  parameter int W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   core_valid,
  input  logic [1:0]             core_kind,
  input  logic [1:0]             core_op,
  input  logic [$clog2(WORDS)-1:0] core_word,
  input  logic [W-1:0]           core_wdata,
  input  logic                   evict,
  input  logic                   dir_valid,
  input  logic [1:0]             dir_kind,
  input  logic                   dir_excl,
  input  logic [1:0]             dir_op,
  input  logic [WORDS*W-1:0]     dir_line,
  output logic                   busy,
  output logic                   core_done,
  output logic [W-1:0]           core_rdata,
  output logic                   req_valid,
  output logic [1:0]             req_kind,
  output logic [1:0]             req_op,
  output logic                   msg_valid,
  output logic [1:0]             msg_kind,
  output logic [1:0]             msg_op,
  output logic [WORDS*W-1:0]     msg_line,
  output logic [3:0]             line_tag
);
  localparam int AW = $clog2(WORDS);
  localparam logic [3:0] T_I = 4'b0000, T_S = 4'b0100, T_E = 4'b1000, T_M = 4'b1001;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_UP = 2'd2;
  localparam logic [1:0] D_GNT = 2'd0, D_INV = 2'd1, D_DWN = 2'd2;
  localparam logic [1:0] M_ACK = 2'd0, M_DATA = 2'd1, M_PART = 2'd2;

  function automatic logic [W-1:0] ident(input logic [1:0] op);
    return (op == 2'd1) ? '1 : '0;
  endfunction

  function automatic logic [W-1:0] combine(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a & b;
      2'd2: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  logic [3:0]         tag;
  logic [W-1:0]       mem [WORDS];
  logic [WORDS*W-1:0] flat;
  logic               pend;
  logic [1:0]         pk, po;
  logic [AW-1:0]      pw;
  logic [W-1:0]       pd;

  wire is_u   = tag[3:2] == 2'b11;
  wire is_prv = (tag == T_E) || (tag == T_M);
  wire hit = (core_kind == K_RD && (tag == T_S || is_prv)) ||
             (core_kind == K_WR && is_prv) ||
             (core_kind == K_UP && (is_prv || (is_u && tag[1:0] == core_op)));
  wire [W-1:0] upd    = combine(core_op, mem[core_word], core_wdata);
  wire [W-1:0] fill_w = dir_line[pw*W +: W];
  wire [W-1:0] fill_u = combine(po, fill_w, pd);

  assign busy = pend;
  assign line_tag = tag;

  always_comb
    for (int i = 0; i < WORDS; i++) flat[i*W +: W] = mem[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag <= T_I; pend <= 1'b0; pk <= '0; po <= '0; pw <= '0; pd <= '0;
      core_done <= 1'b0; core_rdata <= '0;
      req_valid <= 1'b0; req_kind <= '0; req_op <= '0;
      msg_valid <= 1'b0; msg_kind <= '0; msg_op <= '0; msg_line <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      core_done <= 1'b0;
      req_valid <= 1'b0;
      msg_valid <= 1'b0;
      if (dir_valid) begin
        case (dir_kind)
          D_GNT: if (pend) begin
            pend <= 1'b0;
            core_done <= 1'b1;
            if (pk == K_UP && !dir_excl) begin
              for (int i = 0; i < WORDS; i++) mem[i] <= ident(po);
              mem[pw] <= pd;
              tag <= {2'b11, po};
              core_rdata <= pd;
            end else begin
              for (int i = 0; i < WORDS; i++) mem[i] <= dir_line[i*W +: W];
              case (pk)
                K_RD: begin tag <= dir_excl ? T_E : T_S; core_rdata <= fill_w; end
                K_WR: begin mem[pw] <= pd; tag <= T_M; core_rdata <= pd; end
                default: begin mem[pw] <= fill_u; tag <= T_M; core_rdata <= fill_u; end
              endcase
            end
          end
          D_INV: begin
            msg_valid <= 1'b1; msg_line <= flat; msg_op <= tag[1:0];
            msg_kind <= is_u ? M_PART : (tag == T_M ? M_DATA : M_ACK);
            tag <= T_I;
          end
          D_DWN: begin
            msg_valid <= 1'b1; msg_line <= flat; msg_op <= tag[1:0];
            if (is_u || is_prv) begin
              msg_kind <= is_u ? M_PART : M_DATA;
              for (int i = 0; i < WORDS; i++) mem[i] <= ident(dir_op);
              tag <= {2'b11, dir_op};
            end else begin
              msg_kind <= M_ACK;
              tag <= T_I;
            end
          end
          default: ;
        endcase
      end else if (evict && !pend) begin
        if (is_u || tag == T_M) begin
          msg_valid <= 1'b1; msg_line <= flat; msg_op <= tag[1:0];
          msg_kind <= is_u ? M_PART : M_DATA;
        end
        tag <= T_I;
      end else if (core_valid && !pend && core_kind != 2'd3) begin
        if (hit) begin
          core_done <= 1'b1;
          case (core_kind)
            K_RD: core_rdata <= mem[core_word];
            K_WR: begin mem[core_word] <= core_wdata; tag <= T_M; core_rdata <= core_wdata; end
            default: begin
              mem[core_word] <= upd; core_rdata <= upd;
              if (!is_u) tag <= T_M;
            end
          endcase
        end else begin
          pend <= 1'b1; pk <= core_kind; po <= core_op; pw <= core_word; pd <= core_wdata;
          req_valid <= 1'b1; req_kind <= core_kind; req_op <= core_op;
          if (is_u) begin
            msg_valid <= 1'b1; msg_kind <= M_PART; msg_op <= tag[1:0]; msg_line <= flat;
          end
          tag <= T_I;
        end
      end
    end
  end

  assert_inv_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dir_valid && dir_kind == D_INV |=> line_tag == T_I && msg_valid);
  assert_stall_no_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(dir_valid && dir_kind == D_GNT) |=> !core_done);
  assert_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);
  assert_partial_from_u_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == M_PART |-> $past(line_tag[3:2]) == 2'b11);
  assert_u_op_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_tag[3:2] == 2'b11 && $past(line_tag[3:2]) == 2'b11 && !$past(dir_valid)
      |-> line_tag[1:0] == $past(line_tag[1:0]));
  assert_grant_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dir_valid && dir_kind == D_GNT |=> !busy && core_done);
endmodule

// File: tb/upd_line_ctrl_test.sv
module upd_line_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic core_valid, evict, dir_valid, dir_excl;
  logic [1:0] core_kind, core_op, dir_kind, dir_op;
  logic [2:0] core_word;
  logic [63:0] core_wdata;
  logic [511:0] dir_line;
  logic busy, core_done, req_valid, msg_valid;
  logic [63:0] core_rdata;
  logic [1:0] req_kind, req_op, msg_kind, msg_op;
  logic [511:0] msg_line;
  logic [3:0] line_tag;

  upd_line_ctrl uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string cur = "R1", lab = "R1";

  // behavioural reference
  logic [3:0] mt; logic [63:0] mm [8]; bit mp; logic [1:0] mk, mo; int mw; logic [63:0] md;
  bit e_done, e_req, e_msg; logic [63:0] e_rd; logic [1:0] e_rk, e_ro, e_mk, e_mo; logic [511:0] e_ml;

  function automatic logic [63:0] fid(input logic [1:0] op);
    return op == 1 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0;
  endfunction
  function automatic logic [63:0] fapp(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    if (op == 0) return a + b;
    if (op == 1) return a & b;
    if (op == 2) return a | b;
    return a ^ b;
  endfunction
  function automatic logic [511:0] mflat();
    logic [511:0] r;
    for (int i = 0; i < 8; i++) r[i*64 +: 64] = mm[i];
    return r;
  endfunction
  function automatic logic [511:0] mkline(input logic [63:0] seed);
    logic [511:0] r;
    for (int i = 0; i < 8; i++) r[i*64 +: 64] = seed + 64'h0101_0000_0000_0011 * i;
    return r;
  endfunction

  always @(posedge clk) begin
    bit u, prv, h;
    lab = cur;
    cycles++;
    if (!rst_n) begin
      mt = 0; mp = 0; e_done = 0; e_req = 0; e_msg = 0; e_rd = 0;
      for (int i = 0; i < 8; i++) mm[i] = 0;
    end else begin
      e_done = 0; e_req = 0; e_msg = 0;
      u = mt[3:2] == 2'b11; prv = (mt == 4'b1000 || mt == 4'b1001);
      if (dir_valid) begin
        if (dir_kind == 0) begin
          if (mp) begin
            mp = 0; e_done = 1;
            if (mk == 2 && !dir_excl) begin
              for (int i = 0; i < 8; i++) mm[i] = fid(mo);
              mm[mw] = md; mt = {2'b11, mo}; e_rd = md;
            end else begin
              for (int i = 0; i < 8; i++) mm[i] = dir_line[i*64 +: 64];
              if (mk == 0) begin mt = dir_excl ? 4'b1000 : 4'b0100; e_rd = mm[mw]; end
              else if (mk == 1) begin mm[mw] = md; mt = 4'b1001; e_rd = md; end
              else begin mm[mw] = fapp(mo, mm[mw], md); mt = 4'b1001; e_rd = mm[mw]; end
            end
          end
        end else if (dir_kind == 1) begin
          e_msg = 1; e_ml = mflat(); e_mo = mt[1:0];
          e_mk = u ? 2 : (mt == 4'b1001 ? 1 : 0); mt = 0;
        end else if (dir_kind == 2) begin
          e_msg = 1; e_ml = mflat(); e_mo = mt[1:0];
          if (u || prv) begin
            e_mk = u ? 2 : 1;
            for (int i = 0; i < 8; i++) mm[i] = fid(dir_op);
            mt = {2'b11, dir_op};
          end else begin e_mk = 0; mt = 0; end
        end
      end else if (evict && !mp) begin
        if (u || mt == 4'b1001) begin e_msg = 1; e_ml = mflat(); e_mo = mt[1:0]; e_mk = u ? 2 : 1; end
        mt = 0;
      end else if (core_valid && !mp && core_kind != 3) begin
        h = (core_kind == 0 && (mt == 4'b0100 || prv)) || (core_kind == 1 && prv) ||
            (core_kind == 2 && (prv || (u && mt[1:0] == core_op)));
        if (h) begin
          e_done = 1;
          if (core_kind == 0) e_rd = mm[core_word];
          else if (core_kind == 1) begin mm[core_word] = core_wdata; mt = 4'b1001; e_rd = core_wdata; end
          else begin mm[core_word] = fapp(core_op, mm[core_word], core_wdata); e_rd = mm[core_word]; if (!u) mt = 4'b1001; end
        end else begin
          mp = 1; mk = core_kind; mo = core_op; mw = core_word; md = core_wdata;
          e_req = 1; e_rk = core_kind; e_ro = core_op;
          if (u) begin e_msg = 1; e_mk = 2; e_mo = mt[1:0]; e_ml = mflat(); end
          mt = 0;
        end
      end
    end
  end

  task automatic bad(input string f, input logic [511:0] g, input logic [511:0] e);
    fails++;
    $display("FAIL %s %s got %0h expected %0h", lab, f, g, e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (line_tag !== mt) bad("line_tag", 512'(line_tag), 512'(mt));
      else if (busy !== mp) bad("busy", 512'(busy), 512'(mp));
      else if (core_done !== e_done) bad("core_done", 512'(core_done), 512'(e_done));
      else if (e_done && core_rdata !== e_rd) bad("core_rdata", 512'(core_rdata), 512'(e_rd));
      else if (req_valid !== e_req) bad("req_valid", 512'(req_valid), 512'(e_req));
      else if (e_req && {req_kind, req_op} !== {e_rk, e_ro}) bad("req", 512'({req_kind, req_op}), 512'({e_rk, e_ro}));
      else if (msg_valid !== e_msg) bad("msg_valid", 512'(msg_valid), 512'(e_msg));
      else if (e_msg && msg_kind !== e_mk) bad("msg_kind", 512'(msg_kind), 512'(e_mk));
      else if (e_msg && e_mk == 2 && msg_op !== e_mo) bad("msg_op", 512'(msg_op), 512'(e_mo));
      else if (e_msg && e_mk != 0 && msg_line !== e_ml) bad("msg_line", msg_line, e_ml);
    end
  end

  task automatic clr();
    core_valid = 0; core_kind = 0; core_op = 0; core_word = 0; core_wdata = 0;
    evict = 0; dir_valid = 0; dir_kind = 3; dir_excl = 0; dir_op = 0; dir_line = 0;
  endtask
  task automatic cr(input logic [1:0] k, input logic [1:0] op, input logic [2:0] w, input logic [63:0] d);
    core_valid = 1; core_kind = k; core_op = op; core_word = w; core_wdata = d;
    @(negedge clk); clr();
  endtask
  task automatic dm(input logic [1:0] k, input bit ex, input logic [1:0] op, input logic [63:0] seed);
    dir_valid = 1; dir_kind = k; dir_excl = ex; dir_op = op; dir_line = mkline(seed);
    @(negedge clk); clr();
  endtask
  task automatic ev();
    evict = 1; @(negedge clk); clr();
  endtask
  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur = "R1"; gap(2);
    cur = "R5"; cr(0, 0, 3, 0); cr(1, 0, 1, 5); gap(1);
    cur = "R2"; dm(0, 0, 0, 64'h1000); gap(1);
    cur = "R3"; cr(0, 0, 5, 0); cr(1, 0, 2, 64'h22);
    cur = "R6"; dm(0, 1, 0, 64'h2000);
    cur = "R3"; cr(1, 0, 4, 64'hAA); cr(0, 0, 2, 0);
    cur = "R4"; cr(2, 0, 4, 64'h5); cr(2, 3, 4, 64'hFF); cr(2, 0, 4, 64'hFFFF_FFFF_FFFF_FFFF);
    cur = "R9"; dm(2, 0, 3, 0); gap(1);
    cur = "R4"; cr(2, 3, 2, 64'hF0); cr(2, 3, 2, 64'h0F);
    cur = "R11"; cr(2, 0, 2, 64'h7); dm(0, 0, 0, 0); cr(2, 0, 5, 64'h3);
    cur = "R8"; dm(1, 0, 0, 0);
    cur = "R7"; cr(2, 1, 6, 64'h0F0F); dm(0, 0, 0, 0);
    cur = "R10"; ev(); gap(1);
    cur = "R6"; cr(2, 2, 1, 64'h80); dm(0, 1, 0, 64'h3000); gap(1);
    cur = "R12"; core_valid = 1; core_kind = 1; core_word = 0; core_wdata = 9;
    dir_valid = 1; dir_kind = 1; @(negedge clk); clr(); gap(1);
    core_valid = 1; core_kind = 0; evict = 1; @(negedge clk); clr(); gap(1);
    cur = "R13"; dm(0, 1, 0, 64'h4000); gap(1);
    cur = "R10"; cr(0, 0, 7, 0); dm(0, 1, 0, 64'h5000); ev(); gap(1);
    cur = "R9"; cr(0, 0, 1, 0); dm(0, 0, 0, 64'h6000); dm(2, 0, 0, 0); dm(2, 0, 1, 0); gap(1);
    cur = "R11"; cr(2, 2, 0, 64'h1); dm(0, 0, 0, 0); cr(0, 0, 0, 0); dm(0, 1, 0, 64'h7000); gap(1);
    cur = "R10"; cr(1, 0, 3, 64'h33); ev(); cr(0, 0, 3, 0); dm(0, 0, 0, 64'h8000); ev(); gap(1);
    cur = "R8"; cr(1, 0, 0, 1); dm(0, 0, 0, 64'h9000); dm(1, 0, 0, 0); dm(1, 0, 0, 0); gap(1);
    cur = "R9"; cr(2, 0, 3, 64'h9); dm(0, 0, 0, 0); cr(2, 0, 3, 64'h4); dm(2, 0, 1, 0);
    cur = "R4"; cr(2, 1, 3, 64'h00FF); cr(2, 1, 3, 64'h0F0F);
    cur = "R11"; cr(1, 0, 3, 64'h5); dm(0, 0, 0, 64'hA000); gap(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule